// File: doc/BRIEF.md
# Predicated Vector Condition-Field Writeback Sequencer

This block runs one vector of condition-field logic operations, one element per clock, against a small internal file of 4-bit condition fields. A start pulse captures the vector length, the predicate mask and the mode controls. From then on the sequencer walks the element index upward from zero. For each element it reads two source fields, combines them with a selected logic operation, and then decides whether the result is written back to the destination field.

That decision depends on four things: the element's predicate bit, a zero-fill enable, a fill constant, and a test on the operation's own result. An active element is stored only when its tested bit matches a wanted value. A masked-out element is either skipped, or replaced by copies of the fill constant when zero-fill is on. Results come in two forms. In field form the whole 4-bit field is the result. In bit form a single bit of the field is the result, and a one-hot bit mask keeps the other three bits unchanged.

The file can be preloaded through a load port while no vector is running. Only the predicated-result mode code starts a run. The other mode codes leave the unit idle.

Top module: `crvec_seq`

## Requirements
- R1: A start pulse with mode code 2'b11 and a vector length of 1 to 8 makes `busy` high for exactly that many cycles, one element per cycle, starting one cycle after the start. Element i (counting from 0) writes to field (dst_base + i) mod 16 and reads its sources at (srca_base + i) mod 16 and (srcb_base + i) mod 16. `wr_en` is never high while `busy` is low.
- R2: A start with mode code 2'b00, 2'b01 or 2'b10, or with a vector length of 0 or above 8, is ignored. `busy` stays low and nothing is written.
- R3: When `zero_en`=0 and element i's predicate bit (`pred[i]`) is 0, the element produces no write.
- R4: When `zero_en`=1 and the predicate bit is 0, a write always happens, with no result test. In field form the data is four copies of `fill_val` and the mask is 4'b1111. In bit form the mask is one-hot at `bit_sel`, the data holds `fill_val` at that position and zeros elsewhere.
- R5: An active element in field form (`bit_mode`=0) takes the 4-bit result and tests result[`bit_sel`]. It writes the whole result, with mask 4'b1111, only if the tested bit equals `want_val`.
- R6: An active element in bit form (`bit_mode`=1) computes one bit from the two sources' bits at position `bit_sel` and tests that bit. It writes only if the bit equals `want_val`. The mask is one-hot at `bit_sel`, and the data holds the bit there with zeros elsewhere.
- R7: `op_sel` picks the operation: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOR.
- R8: A write by an element is visible to every later element's source reads in the same vector. A bit-form write changes only the masked bit of the field.
- R9: `done` pulses high for exactly one cycle, in the cycle after the last element, and `busy` is low in that cycle.
- R10: While `busy` is high, `start` and `ld_en` are ignored. A load with `busy` low writes all four bits of `ld_addr`, and takes effect from the next cycle.
- R11: After reset, `busy`, `done` and `wr_en` are 0 and all 16 fields hold 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a vector when idle |
| mode | input | 2 | Mode code; only 2'b11 runs |
| vec_len | input | 4 | Number of elements, 1..8 |
| pred | input | 8 | Predicate mask, bit i for element i |
| zero_en | input | 1 | Fill masked-out elements instead of skipping |
| fill_val | input | 1 | Constant written for masked-out elements |
| want_val | input | 1 | Value the tested result bit must equal to store |
| bit_mode | input | 1 | 1: single-bit result, 0: whole field |
| bit_sel | input | 2 | Bit position tested / written |
| op_sel | input | 2 | Logic operation select |
| dst_base | input | 4 | Destination field base |
| srca_base | input | 4 | First source field base |
| srcb_base | input | 4 | Second source field base |
| ld_en | input | 1 | Preload write strobe |
| ld_addr | input | 4 | Preload field address |
| ld_data | input | 4 | Preload field value |
| busy | output | 1 | Vector in progress |
| done | output | 1 | One-cycle end-of-vector pulse |
| wr_en | output | 1 | Element write strobe this cycle |
| wr_addr | output | 4 | Element write field address |
| wr_mask | output | 4 | Element write bit mask |
| wr_data | output | 4 | Element write data |

## Verification
The hardest situation to create from the ports is a chain inside one vector. In such a chain a later element reads a field that an earlier element of the same vector has just partly rewritten in bit form. The bench creates it by setting the first source base one below the destination base, so that element i reads what element i-1 wrote. It mixes predicate patterns and fill settings so that both stored and cancelled writes feed the chain.

Ignored starts and loads issued in the middle of a run are the second hard case. The bench checks them by reading the targeted field back afterwards, through a one-element vector that rewrites the field onto itself.

// File: rtl/crvec_pkg.sv
package crvec_pkg;
    localparam int unsigned FW = 4;
    localparam int unsigned SW = $clog2(FW);

    typedef enum logic [1:0] {
        MODE_REDUCE = 2'b00,
        MODE_FF_LO  = 2'b01,
        MODE_FF_HI  = 2'b10,
        MODE_PRED   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_XOR = 2'b10,
        OP_NOR = 2'b11
    } crop_e;

    function automatic logic [FW-1:0] cr_apply(crop_e op, logic [FW-1:0] a, logic [FW-1:0] b);
        case (op)
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_XOR:  return a ^ b;
            default: return ~(a | b);
        endcase
    endfunction
endpackage

// File: rtl/crvec_file.sv
module crvec_file
    import crvec_pkg::*;
#(
    parameter int unsigned NFIELD = 16,
    localparam int unsigned AW = $clog2(NFIELD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [FW-1:0] wmask,
    input  logic [FW-1:0] wdata,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [FW-1:0] rda,
    output logic [FW-1:0] rdb
);
    logic [FW-1:0] f_d [NFIELD];
    logic [FW-1:0] f_q [NFIELD];

    always_comb begin
        f_d = f_q;
        if (we) begin
            f_d[waddr] = (f_q[waddr] & ~wmask) | (wdata & wmask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{default: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign rda = f_q[ra];
    assign rdb = f_q[rb];

    // R8: bits outside the write mask keep their previous value
    p_masked_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((f_q[$past(waddr)] & ~$past(wmask)) == ($past(f_q[waddr]) & ~$past(wmask))));
endmodule

// File: rtl/crvec_elem.sv
module crvec_elem
    import crvec_pkg::*;
(
    input  logic          run,
    input  logic          pred_bit,
    input  logic          zero_en,
    input  logic          fill_val,
    input  logic          want_val,
    input  logic          bit_mode,
    input  logic [SW-1:0] bit_sel,
    input  crop_e         op,
    input  logic [FW-1:0] src_a,
    input  logic [FW-1:0] src_b,
    output logic          we,
    output logic [FW-1:0] mask,
    output logic [FW-1:0] data
);
    logic [FW-1:0] res_fld;
    logic [FW-1:0] res_bit;
    logic          probe;

    always_comb begin
        res_fld = cr_apply(op, src_a, src_b);
        res_bit = cr_apply(op, FW'(src_a[bit_sel]), FW'(src_b[bit_sel]));
        probe   = bit_mode ? res_bit[0] : res_fld[bit_sel];
        mask    = bit_mode ? (FW'(1) << bit_sel) : '1;
        if (!pred_bit) begin
            we   = run && zero_en;
            data = bit_mode ? (FW'(fill_val) << bit_sel) : {FW{fill_val}};
        end else begin
            we   = run && (probe == want_val);
            data = bit_mode ? (FW'(res_bit[0]) << bit_sel) : res_fld;
        end
    end
endmodule

// File: rtl/crvec_seq.sv
module crvec_seq
    import crvec_pkg::*;
#(
    parameter int unsigned NFIELD = 16,
    parameter int unsigned MAXVL  = 8,
    localparam int unsigned AW  = $clog2(NFIELD),
    localparam int unsigned VLW = $clog2(MAXVL + 1),
    localparam int unsigned IW  = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [VLW-1:0]   vec_len,
    input  logic [MAXVL-1:0] pred,
    input  logic             zero_en,
    input  logic             fill_val,
    input  logic             want_val,
    input  logic             bit_mode,
    input  logic [SW-1:0]    bit_sel,
    input  logic [1:0]       op_sel,
    input  logic [AW-1:0]    dst_base,
    input  logic [AW-1:0]    srca_base,
    input  logic [AW-1:0]    srcb_base,
    input  logic             ld_en,
    input  logic [AW-1:0]    ld_addr,
    input  logic [FW-1:0]    ld_data,
    output logic             busy,
    output logic             done,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [FW-1:0]    wr_mask,
    output logic [FW-1:0]    wr_data
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IW-1:0]    idx;
        logic [IW-1:0]    last;
        logic [MAXVL-1:0] pred;
        logic             zero_en;
        logic             fill_val;
        logic             want_val;
        logic             bit_mode;
        logic [SW-1:0]    bit_sel;
        crop_e            op;
        logic [AW-1:0]    dst;
        logic [AW-1:0]    sa;
        logic [AW-1:0]    sb;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    always_comb begin
        accept = start && !s_q.busy && (mode == MODE_PRED)
              && (vec_len != '0) && (vec_len <= VLW'(MAXVL));
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            if (s_q.idx == s_q.last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end else if (accept) begin
            s_d.busy     = 1'b1;
            s_d.idx      = '0;
            s_d.last     = IW'(vec_len - 1'b1);
            s_d.pred     = pred;
            s_d.zero_en  = zero_en;
            s_d.fill_val = fill_val;
            s_d.want_val = want_val;
            s_d.bit_mode = bit_mode;
            s_d.bit_sel  = bit_sel;
            s_d.op       = crop_e'(op_sel);
            s_d.dst      = dst_base;
            s_d.sa       = srca_base;
            s_d.sb       = srcb_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic [FW-1:0] rd_a, rd_b;
    logic          el_we;
    logic [FW-1:0] el_mask, el_data;
    logic [AW-1:0] el_addr;

    assign el_addr = s_q.dst + AW'(s_q.idx);

    crvec_elem u_elem (
        .run      (s_q.busy),
        .pred_bit (s_q.pred[s_q.idx]),
        .zero_en  (s_q.zero_en),
        .fill_val (s_q.fill_val),
        .want_val (s_q.want_val),
        .bit_mode (s_q.bit_mode),
        .bit_sel  (s_q.bit_sel),
        .op       (s_q.op),
        .src_a    (rd_a),
        .src_b    (rd_b),
        .we       (el_we),
        .mask     (el_mask),
        .data     (el_data)
    );

    crvec_file #(.NFIELD(NFIELD)) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (s_q.busy ? el_we : ld_en),
        .waddr (s_q.busy ? el_addr : ld_addr),
        .wmask (s_q.busy ? el_mask : {FW{1'b1}}),
        .wdata (s_q.busy ? el_data : ld_data),
        .ra    (s_q.sa + AW'(s_q.idx)),
        .rb    (s_q.sb + AW'(s_q.idx)),
        .rda   (rd_a),
        .rdb   (rd_b)
    );

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign wr_en   = el_we;
    assign wr_addr = el_addr;
    assign wr_mask = el_mask;
    assign wr_data = el_data;

    // R1: element writes only during a run
    p_write_in_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
    // R2: other mode codes never start a run
    p_idle_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (mode != MODE_PRED)) |=> !busy);
    // R3: masked-out element without zero-fill is skipped
    p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !s_q.zero_en && !s_q.pred[s_q.idx]) |-> !wr_en);
    // R4: zero-fill always writes the fill constant under the mask
    p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.zero_en && !s_q.pred[s_q.idx])
        |-> (wr_en && ((wr_data & wr_mask) == (s_q.fill_val ? wr_mask : '0))));
    // R6: bit-form writes touch exactly one bit
    p_bit_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_q.bit_mode) |-> ($countones(wr_mask) == 1));
    // R9: done follows the last element and ends the run
    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (s_q.idx == s_q.last)) |=> (done && !busy));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: a start during a run does not disturb the captured vector
    p_hold_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (s_q.idx != s_q.last)) |=> (busy && $stable(s_q.dst) && $stable(s_q.last)));
endmodule

// File: tb/crvec_seq_test.sv
module crvec_seq_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, start, zero_en, fill_val, want_val, bit_mode, ld_en;
    logic [1:0] mode, bit_sel, op_sel;
    logic [3:0] vec_len, dst_base, srca_base, srcb_base, ld_addr, ld_data;
    logic [7:0] pred;
    logic       busy, done, wr_en;
    logic [3:0] wr_addr, wr_mask, wr_data;

    crvec_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vec_len(vec_len),
        .pred(pred), .zero_en(zero_en), .fill_val(fill_val), .want_val(want_val),
        .bit_mode(bit_mode), .bit_sel(bit_sel), .op_sel(op_sel),
        .dst_base(dst_base), .srca_base(srca_base), .srcb_base(srcb_base),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_mask(wr_mask), .wr_data(wr_data)
    );

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    logic [3:0] mdl [16];

    bit         q_en   [$];
    logic [3:0] q_addr [$];
    logic [3:0] q_mask [$];
    logic [3:0] q_data [$];
    string      q_tag  [$];

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_op(int op, logic [3:0] a, logic [3:0] b);
        case (op)
            0: return a & b;
            1: return a | b;
            2: return a ^ b;
            default: return ~(a | b);
        endcase
    endfunction

    // monitor: pops one expected item per running cycle
    bit m_en; logic [3:0] m_a, m_m, m_d; string m_t;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy) begin
                if (q_en.size() == 0) begin
                    chk(0, "R1", "busy with no element expected", 1, 0);
                end else begin
                    m_en = q_en.pop_front(); m_a = q_addr.pop_front();
                    m_m = q_mask.pop_front(); m_d = q_data.pop_front(); m_t = q_tag.pop_front();
                    chk(wr_en == m_en, m_t, "wr_en", wr_en, m_en);
                    if (m_en && wr_en) begin
                        chk(wr_addr == m_a, "R1", "wr_addr", wr_addr, m_a);
                        chk(wr_mask == m_m, m_t, "wr_mask", wr_mask, m_m);
                        chk(wr_data == m_d, m_t, "wr_data", wr_data, m_d);
                    end
                end
            end else begin
                chk(wr_en == 1'b0, "R1", "wr_en while idle", wr_en, 0);
            end
        end
    end

    task automatic load(int addr, logic [3:0] val);
        @(negedge clk);
        ld_en = 1; ld_addr = 4'(addr); ld_data = val;
        @(negedge clk);
        ld_en = 0;
        mdl[addr] = val;
    endtask

    task automatic run_vec(int md, int vl, logic [7:0] pm, bit ze, bit fv, bit wv,
                           bit bm, int bs, int op, int dst, int sa, int sb, bit disturb);
        bit accept = (md == 3) && (vl >= 1) && (vl <= 8);
        int cnt;
        if (accept) begin
            for (int i = 0; i < vl; i++) begin
                logic [3:0] a, b, res, rb4, msk, dat;
                bit en, probe;
                string tg;
                int addr = (dst + i) % 16;
                a = mdl[(sa + i) % 16];
                b = mdl[(sb + i) % 16];
                res = ref_op(op, a, b);
                rb4 = ref_op(op, {3'b0, a[bs]}, {3'b0, b[bs]});
                msk = bm ? (4'b1 << bs) : 4'hF;
                if (!pm[i]) begin
                    tg = ze ? "R4" : "R3";
                    en = ze;
                    dat = bm ? (4'(fv) << bs) : {4{fv}};
                end else begin
                    tg = bm ? "R6" : "R5";
                    probe = bm ? rb4[0] : res[bs];
                    en = (probe == wv);
                    dat = bm ? (4'(rb4[0]) << bs) : res;
                end
                if (en) mdl[addr] = (mdl[addr] & ~msk) | (dat & msk);
                q_en.push_back(en); q_addr.push_back(4'(addr));
                q_mask.push_back(msk); q_data.push_back(dat); q_tag.push_back(tg);
            end
        end
        @(negedge clk);
        start = 1; mode = 2'(md); vec_len = 4'(vl); pred = pm; zero_en = ze;
        fill_val = fv; want_val = wv; bit_mode = bm; bit_sel = 2'(bs); op_sel = 2'(op);
        dst_base = 4'(dst); srca_base = 4'(sa); srcb_base = 4'(sb);
        @(negedge clk);
        start = 0;
        if (accept) begin
            cnt = 0;
            while (busy) begin
                cnt++;
                if (disturb && cnt == 1) begin
                    // R10: start and load inside a run must be ignored
                    start = 1; mode = 2'b11; vec_len = 4'd2; dst_base = 4'(sa);
                    ld_en = 1; ld_addr = 4'((sa + vl - 1) % 16); ld_data = ~mdl[(sa + vl - 1) % 16];
                end else begin
                    start = 0; ld_en = 0;
                end
                @(negedge clk);
            end
            start = 0; ld_en = 0;
            chk(cnt == vl, "R1", "busy cycles", cnt, vl);
            chk(done == 1'b1, "R9", "done after last", done, 1);
            @(negedge clk);
            chk(done == 1'b0, "R9", "done single pulse", done, 0);
            chk(q_en.size() == 0, "R1", "elements left over", q_en.size(), 0);
        end else begin
            for (int k = 0; k < 3; k++) begin
                chk(busy == 1'b0, "R2", "ignored start busy", busy, 0);
                chk(done == 1'b0, "R2", "ignored start done", done, 0);
                @(negedge clk);
            end
        end
    endtask

    // rewrites a field onto itself so its value shows on wr_data
    task automatic peek(int addr);
        run_vec(3, 1, 8'h01, 0, 0, mdl[addr][0], 0, 0, 1, addr, addr, addr, 0);
    endtask

    initial begin
        rst_n = 0; start = 0; mode = 0; vec_len = 0; pred = 0; zero_en = 0; fill_val = 0;
        want_val = 0; bit_mode = 0; bit_sel = 0; op_sel = 0; dst_base = 0; srca_base = 0;
        srcb_base = 0; ld_en = 0; ld_addr = 0; ld_data = 0;
        for (int i = 0; i < 16; i++) mdl[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state of outputs and file
        chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
        chk(done == 1'b0, "R11", "done after reset", done, 0);
        chk(wr_en == 1'b0, "R11", "wr_en after reset", wr_en, 0);
        peek(0); peek(9); peek(15);
        // R7 NOR on cleared fields gives all ones
        run_vec(3, 4, 8'h0F, 0, 0, 1, 0, 2, 3, 4, 0, 8, 0);
        for (int i = 0; i < 16; i++) load(i, 4'($urandom));
        peek(3);  // R10: a load while idle lands
        // R7: each operation in both forms
        for (int op = 0; op < 4; op++) begin
            run_vec(3, 8, 8'hFF, 0, 0, 1, 0, op, op, 8, 0, 4, 0);
            run_vec(3, 8, 8'hFF, 0, 0, 0, 1, 3 - op, op, 0, 8, 12, 0);
        end
        // R3 skip and R4 fill in both forms
        run_vec(3, 8, 8'hA5, 0, 1, 1, 0, 1, 2, 2, 9, 10, 0);
        run_vec(3, 8, 8'h5A, 1, 1, 0, 0, 0, 1, 3, 9, 10, 0);
        run_vec(3, 8, 8'h00, 1, 0, 1, 1, 3, 0, 7, 1, 2, 0);
        run_vec(3, 6, 8'h33, 1, 1, 1, 1, 2, 2, 12, 5, 6, 0);
        // R2: other modes and illegal lengths
        run_vec(0, 4, 8'hFF, 1, 1, 1, 0, 0, 0, 0, 1, 2, 0);
        run_vec(1, 4, 8'hFF, 1, 1, 1, 0, 0, 0, 0, 1, 2, 0);
        run_vec(2, 4, 8'hFF, 1, 1, 1, 0, 0, 0, 0, 1, 2, 0);
        run_vec(3, 0, 8'hFF, 1, 1, 1, 0, 0, 0, 0, 1, 2, 0);
        run_vec(3, 9, 8'hFF, 1, 1, 1, 0, 0, 0, 0, 1, 2, 0);
        for (int i = 0; i < 16; i++) peek(i);
        // R8: element i reads what element i-1 wrote, bit form and field form
        run_vec(3, 8, 8'hFF, 0, 0, 1, 1, 1, 2, 5, 4, 4, 0);
        run_vec(3, 8, 8'h7E, 1, 1, 0, 1, 3, 3, 6, 5, 14, 0);
        run_vec(3, 8, 8'hFF, 0, 0, 0, 0, 0, 2, 10, 9, 2, 0);
        for (int i = 0; i < 16; i++) peek(i);
        // R10: start and load during a run
        run_vec(3, 5, 8'hFF, 0, 0, 1, 0, 1, 1, 0, 6, 6, 1);
        peek(10);
        run_vec(3, 3, 8'h05, 1, 0, 0, 1, 2, 0, 11, 3, 4, 1);
        peek(5);
        // random vectors
        for (int n = 0; n < 300; n++) begin
            int md = ($urandom % 8 == 0) ? int'($urandom % 3) : 3;
            int vl = ($urandom % 10 == 0) ? 0 : int'($urandom % 8) + 1;
            run_vec(md, vl, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), int'($urandom % 4), int'($urandom % 4),
                    int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
                    (vl >= 3) && ($urandom % 4 == 0));
            if (n % 50 == 0) load(int'($urandom % 16), 4'($urandom));
        end
        for (int i = 0; i < 16; i++) peek(i);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual %0h expected %0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule